// File: doc/BRIEF.md
# Minimal Accumulator Processor Core

This block is a very small stored-program processor. It has sixteen bytes of internal storage, and instructions and data share that space. Each byte read as an instruction splits into two nibbles. The upper nibble selects the operation. The lower nibble is either a storage address or a small immediate value. The core keeps two 8-bit unsigned working registers (an accumulator A and a second operand register B), a carry flag, a zero flag and a 4-bit program counter. Every instruction takes two clock cycles: one to fetch it and one to execute it.

A host fills the storage through a byte-wide load port. This is only possible while reset is asserted. The host then releases reset and controls progress with the run input. Results appear on a registered output port. A one-cycle strobe marks each new output value. The core stops for good on a halt instruction. It also stops for good, with a separate fault flag, when it fetches a byte whose upper nibble has no assigned operation. Only a new reset clears either stop.

Top module: `acc_core`

## Requirements
- R1: While rst is high, the program counter, A, B, both flags and the output register go to zero, and halted, fault and out_stb are low. After release, execution starts at address 0.
- R2: The load port (load_we, load_addr, load_data) writes storage only while rst is high. A write attempted with rst low has no effect on storage.
- R3: Each instruction takes exactly one fetch cycle and one execute cycle. The fetch advances the program counter modulo 16, so execution continues from address 15 to address 0. The first instruction after reset release completes on the second rising edge.
- R4: Opcode 0x1 (load) copies storage[arg] into A. Opcode 0x5 (immediate) copies the zero-extended 4-bit arg into A. Opcode 0xE (output) copies A into out_q and pulses out_stb high for one cycle. Opcode 0x0 does nothing.
- R5: Opcode 0x2 (add) loads B from storage[arg] and sets A to (A+B) mod 256. Carry becomes the carry out of bit 7, and zero is set when the 8-bit result is 0.
- R6: Opcode 0x3 (subtract) loads B from storage[arg] and sets A to (A−B) mod 256. Carry becomes 1 exactly when A ≥ B, and zero is set when the 8-bit result is 0.
- R7: Opcode 0x6 always loads arg into the program counter. Opcode 0x7 does so only when carry is 1, and opcode 0x8 only when zero is 1. A branch that is not taken continues with the next address.
- R8: Opcode 0x4 (store) writes A into storage[arg]. The stored byte can later be fetched and executed as an instruction.
- R9: Opcode 0xF sets halted. From then until reset, no register, flag, output or storage changes, and out_stb stays low.
- R10: Fetching a byte whose upper nibble is 0x9 to 0xD sets fault instead of executing it. Fault stays set until reset, nothing further executes, and halted stays low.
- R11: While run is low the core holds every register, flag and output. Execution resumes exactly where it stopped when run returns high.
- R12: Only opcodes 0x2 and 0x3 change the flags. In particular, loading 0 with opcode 0x5 does not set the zero flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; also enables the load port |
| run | input | 1 | Execution enable; low freezes the core |
| load_we | input | 1 | Load-port write enable (honoured only in reset) |
| load_addr | input | 4 | Load-port storage address |
| load_data | input | 8 | Load-port byte |
| out_q | output | 8 | Output register, written by the output instruction |
| out_stb | output | 1 | One-cycle pulse when out_q is written |
| halted | output | 1 | Core has executed a halt |
| fault | output | 1 | Core fetched a reserved opcode |

## Verification
The arithmetic path is driven by one probe program. It prints the result, then the carry seen by a conditional branch, then the zero flag seen by a second branch. The program runs for both add and subtract across operand pairs that separate the cases: a plain sum, a wrap through 256, an exact zero result with carry, borrow from zero, equal operands and ordinary subtraction. Because the probe executes immediate loads between the arithmetic and the zero branch, it also shows that those loads leave the flags alone. Other programs cover the following: the exact cycle of the first output, storage writes that are later executed as code across the 15-to-0 wrap, a halt followed by code that must never run, each reserved opcode value, and a pause with a load-port write attempted mid-run.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP = 4'h0,
    OP_LDA = 4'h1,
    OP_ADD = 4'h2,
    OP_SUB = 4'h3,
    OP_STA = 4'h4,
    OP_LDI = 4'h5,
    OP_JMP = 4'h6,
    OP_JC  = 4'h7,
    OP_JZ  = 4'h8,
    OP_OUT = 4'hE,
    OP_HLT = 4'hF
  } opcode_e;

  typedef enum logic {
    PH_FETCH = 1'b0,
    PH_EXEC  = 1'b1
  } phase_e;

  typedef struct packed {
    logic a_from_mem;
    logic a_from_imm;
    logic a_from_alu;
    logic b_load;
    logic flags_upd;
    logic alu_sub;
    logic mem_store;
    logic pc_jump;
    logic out_load;
    logic halt;
  } ctl_t;

  function automatic logic op_is_reserved(input logic [OP_W-1:0] op);
    return (op >= 4'h9) && (op <= 4'hD);
  endfunction

endpackage

// File: rtl/acc_core_mem.sv
module acc_core_mem #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b
);

  localparam int DEPTH = 1 << ADDR_W;

  // Small distributed-RAM style array: one write port, two asynchronous reads
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  assign rd_data_a = cells[rd_addr_a];
  assign rd_data_b = cells[rd_addr_b];

endmodule

// File: rtl/acc_core_alu.sv
module acc_core_alu #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  input  logic              subtract,
  output logic [DATA_W-1:0] result,
  output logic              carry,
  output logic              zero
);

  logic [DATA_W-1:0] rhs_x;
  logic [DATA_W:0]   sum;

  // One adder: subtraction is lhs + ~rhs + 1, whose carry out means no borrow
  always_comb begin
    rhs_x  = subtract ? ~rhs : rhs;
    sum    = {1'b0, lhs} + {1'b0, rhs_x} + (DATA_W+1)'(subtract);
    result = sum[DATA_W-1:0];
    carry  = sum[DATA_W];
    zero   = (sum[DATA_W-1:0] == '0);
  end

endmodule

// File: rtl/acc_core_decode.sv
module acc_core_decode
  import acc_core_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic            carry_flag,
  input  logic            zero_flag,
  output ctl_t            ctl
);

  always_comb begin
    ctl = '0;
    case (opcode_e'(op))
      OP_LDA: ctl.a_from_mem = 1'b1;
      OP_ADD: begin
        ctl.b_load     = 1'b1;
        ctl.a_from_alu = 1'b1;
        ctl.flags_upd  = 1'b1;
      end
      OP_SUB: begin
        ctl.b_load     = 1'b1;
        ctl.a_from_alu = 1'b1;
        ctl.flags_upd  = 1'b1;
        ctl.alu_sub    = 1'b1;
      end
      OP_STA: ctl.mem_store  = 1'b1;
      OP_LDI: ctl.a_from_imm = 1'b1;
      OP_JMP: ctl.pc_jump    = 1'b1;
      OP_JC:  ctl.pc_jump    = carry_flag;
      OP_JZ:  ctl.pc_jump    = zero_flag;
      OP_OUT: ctl.out_load   = 1'b1;
      OP_HLT: ctl.halt       = 1'b1;
      default: ctl = '0;
    endcase
  end

  // R4: at most one source may drive the accumulator in an instruction
  always_comb begin
    p_single_a_source_r4: assert ($onehot0({ctl.a_from_mem, ctl.a_from_imm, ctl.a_from_alu}));
  end

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              load_we,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  output logic [DATA_W-1:0] out_q,
  output logic              out_stb,
  output logic              halted,
  output logic              fault
);

  localparam int IMM_PAD = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] ir;
  logic [DATA_W-1:0] acc_a;
  logic [DATA_W-1:0] reg_b;
  logic              cf;
  logic              zf;
  phase_e            phase;

  logic [OP_W-1:0]   ir_op;
  logic [ADDR_W-1:0] ir_arg;
  logic [DATA_W-1:0] fetch_byte;
  logic [DATA_W-1:0] operand;
  logic              fetch_bad;
  logic              active;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] alu_res;
  logic              alu_c;
  logic              alu_z;
  ctl_t              ctl;

  assign ir_op     = ir[DATA_W-1 -: OP_W];
  assign ir_arg    = ir[ADDR_W-1:0];
  assign fetch_bad = op_is_reserved(fetch_byte[DATA_W-1 -: OP_W]);
  assign active    = run && !halted && !fault;

  // Storage write: load port in reset, store instruction otherwise
  always_comb begin
    if (rst) begin
      mem_we    = load_we;
      mem_waddr = load_addr;
      mem_wdata = load_data;
    end else begin
      mem_we    = active && (phase == PH_EXEC) && ctl.mem_store;
      mem_waddr = ir_arg;
      mem_wdata = acc_a;
    end
  end

  acc_core_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk       (clk),
    .wr_en     (mem_we),
    .wr_addr   (mem_waddr),
    .wr_data   (mem_wdata),
    .rd_addr_a (pc),
    .rd_data_a (fetch_byte),
    .rd_addr_b (ir_arg),
    .rd_data_b (operand)
  );

  acc_core_decode u_dec (
    .op         (ir_op),
    .carry_flag (cf),
    .zero_flag  (zf),
    .ctl        (ctl)
  );

  acc_core_alu #(.DATA_W(DATA_W)) u_alu (
    .lhs      (acc_a),
    .rhs      (operand),
    .subtract (ctl.alu_sub),
    .result   (alu_res),
    .carry    (alu_c),
    .zero     (alu_z)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      ir      <= '0;
      acc_a   <= '0;
      reg_b   <= '0;
      cf      <= 1'b0;
      zf      <= 1'b0;
      out_q   <= '0;
      out_stb <= 1'b0;
      halted  <= 1'b0;
      fault   <= 1'b0;
      phase   <= PH_FETCH;
    end else begin
      out_stb <= 1'b0;
      if (active) begin
        if (phase == PH_FETCH) begin
          if (fetch_bad) begin
            fault <= 1'b1;
          end else begin
            ir    <= fetch_byte;
            pc    <= pc + 1'b1;
            phase <= PH_EXEC;
          end
        end else begin
          phase <= PH_FETCH;
          if (ctl.b_load) reg_b <= operand;
          if (ctl.a_from_mem)      acc_a <= operand;
          else if (ctl.a_from_imm) acc_a <= {{IMM_PAD{1'b0}}, ir_arg};
          else if (ctl.a_from_alu) acc_a <= alu_res;
          if (ctl.flags_upd) begin
            cf <= alu_c;
            zf <= alu_z;
          end
          if (ctl.pc_jump) pc <= ir_arg;
          if (ctl.out_load) begin
            out_q   <= acc_a;
            out_stb <= 1'b1;
          end
          if (ctl.halt) halted <= 1'b1;
        end
      end
    end
  end

  // R1: a reset cycle leaves the architectural state cleared
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (pc == '0 && acc_a == '0 && reg_b == '0 && !cf && !zf &&
             !halted && !fault && !out_stb && out_q == '0));

  // R3: a good fetch advances the counter by one and enters execute
  p_pc_step_r3: assert property (@(posedge clk) disable iff (rst)
    (active && phase == PH_FETCH && !fetch_bad) |=>
      (pc == $past(pc) + 1'b1) && (phase == PH_EXEC));

  // R4: each strobe presents the accumulator
  p_out_shows_a_r4: assert property (@(posedge clk) disable iff (rst)
    out_stb |-> (out_q == acc_a));

  // R9: a stopped core changes nothing
  p_frozen_after_stop_r9: assert property (@(posedge clk) disable iff (rst)
    (halted || fault) |=> ($stable(pc) && $stable(acc_a) && $stable(out_q) && !out_stb));

  // R10: reserved fetch traps without advancing, and the trap is sticky
  p_reserved_traps_r10: assert property (@(posedge clk) disable iff (rst)
    (active && phase == PH_FETCH && fetch_bad) |=> (fault && $stable(pc)));
  p_fault_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault);

  // R11: with run low the state holds
  p_pause_holds_r11: assert property (@(posedge clk) disable iff (rst)
    !run |=> ($stable(pc) && $stable(acc_a) && $stable(reg_b) && $stable(phase)));

endmodule

// File: tb/acc_core_test.sv
module acc_core_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run = 1'b0;
  logic       load_we = 1'b0;
  logic [3:0] load_addr = '0;
  logic [7:0] load_data = '0;
  logic [7:0] out_q;
  logic       out_stb;
  logic       halted;
  logic       fault;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_core #(.DATA_W(8), .ADDR_W(4)) uut (
    .clk(clk), .rst(rst), .run(run), .load_we(load_we), .load_addr(load_addr),
    .load_data(load_data), .out_q(out_q), .out_stb(out_stb), .halted(halted), .fault(fault)
  );

  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] prog[16];

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_out(input logic [7:0] v, input string req);
    exp_q.push_back(v);
    tag_q.push_back(req);
  endtask

  // Monitor: pop one expectation per output strobe
  always @(negedge clk) begin
    if (!rst && out_stb) begin
      logic [7:0] e;
      string      t;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4", int'(out_q), -1, "unexpected output strobe");
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(out_q == e, t, int'(out_q), int'(e), "output value");
      end
    end
  end

  task automatic fill_halt();
    for (int i = 0; i < 16; i++) prog[i] = 8'hF0;
  endtask

  task automatic boot(input bit start_run);
    rst = 1'b1;
    run = 1'b0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      load_we = 1'b1; load_addr = 4'(i); load_data = prog[i];
    end
    @(negedge clk);
    load_we = 1'b0;
    chk(halted == 1'b0, "R1", int'(halted), 0, "halted in reset");
    chk(fault == 1'b0, "R1", int'(fault), 0, "fault in reset");
    chk(out_q == 8'd0 && out_stb == 1'b0, "R1", int'(out_q), 0, "output in reset");
    run = start_run;
    rst = 1'b0;
  endtask

  task automatic run_to_stop(input bit want_fault, input string req);
    int n = 0;
    while (!(halted || fault) && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk(fault == want_fault, req, int'(fault), int'(want_fault), "fault flag");
    chk(halted == !want_fault, req, int'(halted), int'(!want_fault), "halted flag");
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, req, exp_q.size(), 0, "outputs still pending");
    exp_q.delete();
    tag_q.delete();
  endtask

  task automatic first_out_after(input int n, input string req);
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      chk(out_stb == 1'b0, req, int'(out_stb), 0, "early strobe");
    end
    @(negedge clk);
    chk(out_stb == 1'b1, req, int'(out_stb), 1, "strobe cycle");
  endtask

  initial begin
    int pa[8] = '{200, 128, 3, 0, 255, 5, 7, 0};
    int pb[8] = '{100, 128, 4, 1, 1, 5, 3, 0};

    // R3: LDI 7 then OUT; output strobe follows the fourth edge after release
    fill_halt();
    prog[0] = 8'h57; prog[1] = 8'hE0;
    boot(1'b1);
    expect_out(8'd7, "R3");
    first_out_after(4, "R3");
    run_to_stop(1'b0, "R9");

    // R4: immediate 15 zero-extended, then load byte at address 9
    fill_halt();
    prog[0] = 8'h5F; prog[1] = 8'hE0; prog[2] = 8'h19; prog[3] = 8'hE0; prog[9] = 8'hC3;
    boot(1'b1);
    expect_out(8'd15, "R4");
    expect_out(8'hC3, "R4");
    run_to_stop(1'b0, "R4");

    // R5 R6 R7 R12: arithmetic probe prints result, carry branch, zero branch
    for (int op = 2; op <= 3; op++) begin
      for (int k = 0; k < 8; k++) begin
        int r;
        int c;
        fill_halt();
        prog[0]  = 8'h1E;  prog[1]  = {4'(op), 4'hF};  prog[2]  = 8'hE0;
        prog[3]  = 8'h76;  prog[4]  = 8'h50;  prog[5]  = 8'h67;  prog[6]  = 8'h51;
        prog[7]  = 8'hE0;  prog[8]  = 8'h8B;  prog[9]  = 8'h50;  prog[10] = 8'h6C;
        prog[11] = 8'h51;  prog[12] = 8'hE0;  prog[13] = 8'hF0;
        prog[14] = 8'(pa[k]); prog[15] = 8'(pb[k]);
        if (op == 2) begin
          r = (pa[k] + pb[k]) % 256;
          c = (pa[k] + pb[k] > 255) ? 1 : 0;
        end else begin
          r = (pa[k] - pb[k] + 256) % 256;
          c = (pa[k] >= pb[k]) ? 1 : 0;
        end
        boot(1'b1);
        expect_out(8'(r), (op == 2) ? "R5" : "R6");
        expect_out(8'(c), "R7");
        expect_out((r == 0) ? 8'd1 : 8'd0, "R12");
        run_to_stop(1'b0, (op == 2) ? "R5" : "R6");
      end
    end

    // R8 and R3 wrap: code at 13..15 rewrites byte 0 into a no-op, wraps, runs on
    fill_halt();
    prog[0] = 8'h6D; prog[1] = 8'h56; prog[2] = 8'hE0; prog[3] = 8'hF0;
    prog[13] = 8'h50; prog[14] = 8'h40; prog[15] = 8'h00;
    boot(1'b1);
    expect_out(8'd6, "R8");
    run_to_stop(1'b0, "R8");

    // R9: code after the halt must never run
    fill_halt();
    prog[0] = 8'h59; prog[1] = 8'hE0; prog[2] = 8'hF0; prog[3] = 8'h55; prog[4] = 8'hE0;
    boot(1'b1);
    expect_out(8'd9, "R9");
    run_to_stop(1'b0, "R9");
    repeat (10) @(negedge clk);
    chk(halted == 1'b1 && out_q == 8'd9, "R9", int'(out_q), 9, "state after halt");

    // R10: each reserved upper nibble traps
    for (int b = 9; b <= 13; b++) begin
      fill_halt();
      prog[0] = 8'h53; prog[1] = 8'hE0; prog[2] = {b[3:0], 4'h1};
      prog[3] = 8'h54; prog[4] = 8'hE0;
      boot(1'b1);
      expect_out(8'd3, "R10");
      run_to_stop(1'b1, "R10");
      repeat (6) @(negedge clk);
      chk(fault == 1'b1 && halted == 1'b0, "R10", int'(fault), 1, "sticky fault");
      chk(out_q == 8'd3, "R10", int'(out_q), 3, "output after fault");
    end

    // R2 and R11: pause, attempt a load-port write mid-run, resume
    fill_halt();
    prog[0] = 8'h1F; prog[1] = 8'hE0; prog[2] = 8'hF0; prog[15] = 8'h2A;
    boot(1'b0);
    repeat (3) @(negedge clk);
    chk(out_stb == 1'b0 && halted == 1'b0, "R11", int'(out_stb), 0, "progress while paused");
    load_we = 1'b1; load_addr = 4'hF; load_data = 8'h77;
    @(negedge clk);
    load_we = 1'b0;
    run = 1'b1;
    expect_out(8'h2A, "R2");
    first_out_after(4, "R11");
    run_to_stop(1'b0, "R2");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule